// File: doc/BRIEF.md
# Pairwise Order Phase Detector

This block decodes a multi-wire channel in which each symbol is sent as exactly one level change on every wire. The value of the symbol lies only in the order in which the wires change. For N wires there are N! possible orderings. With the default of four wires that gives 24 symbols, more than the 16 values four plain binary bits can carry. The detector samples the wires on its own clock and records, for every unordered pair of wires, which wire of the pair changed first. When every wire has changed, it presents these order bits together with a one-cycle strobe.

Each pair of wires has its own small order cell, so there are N(N-1)/2 cells. A shared tracker holds three things: the wire levels at the end of the previous symbol, the per-wire "seen" flags, and a timeout counter. If a symbol starts but does not complete within a limit set at a port, the tracker throws away the partial symbol and raises an error strobe. Turning the order matrix into a binary code is left to logic downstream of this block.

Top module: `phase_order_detector`

## Requirements
- R1: The order matrix has N(N-1)/2 bits (N = 4 by default). The pair (k,j) with k<j occupies index k*N - k(k+1)/2 + (j-k-1). For N=4 the mapping is (0,1)->0, (0,2)->1, (0,3)->2, (1,2)->3, (1,3)->4, (2,3)->5. A bit is 1 when wire k changed strictly before wire j, or in the same sample, and 0 when wire j changed first. Each bit is decided in the sample where the earlier wire of its pair changes.
- R2: A wire counts as switched on any change of level relative to its level at the end of the previous symbol, so a rising change and a falling change both count.
- R3: When both wires of a pair first change in the same clock sample, the pair bit is 1: the tie goes to the lower-numbered wire.
- R4: Each input passes through two synchronising flip-flops. sym_valid goes high exactly 3 clock cycles after the last wire's change is applied, stays high for one cycle only, and the seen flags are clear while it is high.
- R5: Every one of the 24 orderings of a 4-wire channel decodes to a different matrix.
- R6: A symbol may start and then fail to complete. In that case tmo_err pulses for one cycle exactly tmo_limit+4 cycles after the first wire's change is applied, and sym_valid does not rise. The partial symbol is discarded, so the next complete symbol decodes correctly.
- R7: After reset, sym_valid, tmo_err and order_mat are all 0, and the reference level of every wire is 0.
- R8: sym_valid and tmo_err are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_in | input | N | Channel wires, asynchronous to clk |
| tmo_limit | input | TMO_W | Cycles a partial symbol may last before it is dropped |
| sym_valid | output | 1 | One-cycle strobe: order_mat holds a complete symbol |
| order_mat | output | N(N-1)/2 | Pairwise order bits |
| tmo_err | output | 1 | One-cycle strobe: a partial symbol timed out |

## Verification
The situations hardest to reach from the ports are same-sample ties and timeout recovery. For a tie, two wires must change between the same pair of clock edges. For recovery, a symbol must be abandoned part-way and the next symbol must then start from mixed reference levels. The bench describes every symbol as a step number per wire and toggles together all wires that share a step. This lets it force ties between adjacent wires, between distant wires and across all four wires at once. For the timeout case it toggles two wires, waits for tmo_err, and then sends a full symbol in which those two wires fall while the other two rise.

// File: rtl/pod_pkg.sv
package pod_pkg;
  // Flat position of pair (k,j), k<j, in the order matrix.
  function automatic int pair_idx(input int k, input int j, input int n);
    return k * n - (k * (k + 1)) / 2 + (j - k - 1);
  endfunction
endpackage

// File: rtl/pod_sync.sv
module pod_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/pod_track.sv
module pod_track #(
  parameter int N     = 4,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     lvl,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic [N-1:0]     sw,
  output logic [N-1:0]     seen,
  output logic             sym_valid,
  output logic             tmo_err
);
  logic [N-1:0]     ref_q, ref_d;
  logic [N-1:0]     seen_q, seen_d;
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             valid_q, valid_d;
  logic             tmo_q, tmo_d;
  logic [N-1:0]     seen_all;
  logic             done, active, hit;

  always_comb begin
    sw       = (lvl ^ ref_q) & ~seen_q;
    seen_all = seen_q | sw;
    done     = &seen_all;
    active   = |seen_q;
    hit      = active & ~done & (cnt_q >= tmo_limit);
    valid_d  = done;
    tmo_d    = hit;
    if (done || hit) begin
      seen_d = '0;
      ref_d  = lvl;
      cnt_d  = '0;
    end else begin
      seen_d = seen_all;
      ref_d  = ref_q;
      cnt_d  = active ? cnt_q + TMO_W'(1) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= '0;
      seen_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      ref_q   <= ref_d;
      seen_q  <= seen_d;
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
      tmo_q   <= tmo_d;
    end
  end

  assign seen      = seen_q;
  assign sym_valid = valid_q;
  assign tmo_err   = tmo_q;

  AST_NO_VALID_WITH_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && tmo_q)); // R8
  AST_VALID_CLEARS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (seen_q == '0)); // R4
  AST_TMO_CLEARS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> (seen_q == '0)); // R6
  AST_TMO_NEEDS_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> $past(seen_q != '0)); // R6
endmodule

// File: rtl/pod_pair_cell.sv
module pod_pair_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_lo,
  input  logic sw_hi,
  input  logic seen_lo,
  input  logic seen_hi,
  output logic bit_q
);
  logic wr_en;
  logic bit_d;

  always_comb begin
    wr_en = ~seen_lo & ~seen_hi & (sw_lo | sw_hi);
    bit_d = sw_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bit_q <= 1'b0;
    else if (wr_en) bit_q <= bit_d;
  end

  AST_PAIR_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_lo || seen_hi) |=> $stable(bit_q)); // R1
  AST_TIE_TO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_lo && !seen_hi && sw_lo && sw_hi) |=> bit_q); // R3
endmodule

// File: rtl/phase_order_detector.sv
module phase_order_detector
  import pod_pkg::*;
#(
  parameter int N     = 4,
  parameter int TMO_W = 16,
  localparam int NP   = N * (N - 1) / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     phase_in,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             sym_valid,
  output logic [NP-1:0]    order_mat,
  output logic             tmo_err
);
  logic [N-1:0] lvl;
  logic [N-1:0] sw;
  logic [N-1:0] seen;

  pod_sync #(.W(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(phase_in), .d_sync(lvl)
  );

  pod_track #(.N(N), .TMO_W(TMO_W)) u_track (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .tmo_limit(tmo_limit),
    .sw(sw), .seen(seen), .sym_valid(sym_valid), .tmo_err(tmo_err)
  );

  for (genvar k = 0; k < N; k++) begin : g_row
    for (genvar j = k + 1; j < N; j++) begin : g_col
      localparam int IDX = pair_idx(k, j, N);
      pod_pair_cell u_cell (
        .clk(clk), .rst_n(rst_n),
        .sw_lo(sw[k]), .sw_hi(sw[j]),
        .seen_lo(seen[k]), .seen_hi(seen[j]),
        .bit_q(order_mat[IDX])
      );
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sym_valid && !tmo_err)); // R7
endmodule

// File: tb/phase_order_detector_tb.sv
module phase_order_detector_tb;
  localparam int N  = 4;
  localparam int NP = 6;
  localparam int TW = 16;

  // Each entry lists the wires first..last, one nibble per wire.
  localparam logic [15:0] PERMS [24] = '{
    16'h0123, 16'h0132, 16'h0213, 16'h0231, 16'h0312, 16'h0321,
    16'h1023, 16'h1032, 16'h1203, 16'h1230, 16'h1302, 16'h1320,
    16'h2013, 16'h2031, 16'h2103, 16'h2130, 16'h2301, 16'h2310,
    16'h3012, 16'h3021, 16'h3102, 16'h3120, 16'h3201, 16'h3210
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  wires;
  logic [TW-1:0] lim;
  logic          sym_valid, tmo_err;
  logic [NP-1:0] order_mat;
  int n_chk = 0, n_fail = 0;
  logic [NP-1:0] seen_mats [24];

  always #10 clk = ~clk;

  phase_order_detector #(.N(N), .TMO_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .phase_in(wires), .tmo_limit(lim),
    .sym_valid(sym_valid), .order_mat(order_mat), .tmo_err(tmo_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Step number per wire, 2 bits each; lower wire wins on equal steps.
  function automatic logic [NP-1:0] exp_mat(input logic [7:0] st);
    logic [NP-1:0] m = '0;
    int idx = 0;
    for (int k = 0; k < N; k++)
      for (int j = k + 1; j < N; j++) begin
        m[idx] = (st[2*k +: 2] <= st[2*j +: 2]);
        idx++;
      end
    return m;
  endfunction

  task automatic send(input logic [7:0] st, input string req,
                      output logic [NP-1:0] got_mat);
    int maxs = 0;
    int lat = 0;
    bit got = 0;
    logic [NP-1:0] e = exp_mat(st);
    got_mat = '0;
    for (int w = 0; w < N; w++) if (int'(st[2*w +: 2]) > maxs) maxs = st[2*w +: 2];
    for (int s = 0; s <= maxs; s++) begin
      @(negedge clk);
      for (int w = 0; w < N; w++) if (int'(st[2*w +: 2]) == s) wires[w] = ~wires[w];
    end
    for (int i = 0; i < 8 && !got; i++) begin
      @(negedge clk);
      lat++;
      if (sym_valid) begin got = 1; got_mat = order_mat; end
    end
    check(got && lat == 3, "R4", "valid latency", lat, 3);
    check(got_mat == e, req, "order matrix", got_mat, e);
    @(negedge clk);
    check(!sym_valid, "R4", "valid width", sym_valid, 0);
    check(!tmo_err, "R8", "no timeout on full symbol", tmo_err, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual expired expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [NP-1:0] m;
    logic [7:0]    st;
    bit            uniq;
    int            n;
    bit            vseen;
    rst_n = 1'b0; wires = '0; lim = 16'd10;
    repeat (3) @(negedge clk);
    check(!sym_valid && !tmo_err && order_mat == '0, "R7", "reset outputs",
          {sym_valid, tmo_err, order_mat}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!sym_valid && !tmo_err, "R7", "idle after reset", {sym_valid, tmo_err}, 0);

    // Table walk: even entries rise from 0 (R1), odd entries fall back (R2).
    for (int i = 0; i < 24; i++) begin
      st = '0;
      for (int p = 0; p < N; p++) st[2*PERMS[i][4*(3-p) +: 4] +: 2] = 2'(p);
      send(st, (i % 2 == 0) ? "R1" : "R2", m);
      seen_mats[i] = m;
    end
    uniq = 1;
    for (int a = 0; a < 24; a++)
      for (int b = a + 1; b < 24; b++) if (seen_mats[a] == seen_mats[b]) uniq = 0;
    check(uniq, "R5", "distinct matrices", uniq, 1);

    // Ties (R3): steps per wire packed {w3,w2,w1,w0}.
    send({2'd1, 2'd2, 2'd0, 2'd0}, "R3", m);   // wires 0,1 together first
    send({2'd0, 2'd1, 2'd0, 2'd2}, "R3", m);   // wires 1,3 together first
    send({2'd0, 2'd0, 2'd0, 2'd0}, "R3", m);   // all four in one sample
    send({2'd1, 2'd1, 2'd0, 2'd0}, "R3", m);   // two pairs of ties

    // Timeout (R6): only wires 0 and 1 change.
    @(negedge clk); wires[0] = ~wires[0];
    n = 0; vseen = 0;
    @(negedge clk); n++; wires[1] = ~wires[1];
    while (!tmo_err && n < 60) begin
      @(negedge clk); n++;
      if (sym_valid) vseen = 1;
    end
    check(n == int'(lim) + 4, "R6", "timeout delay", n, int'(lim) + 4);
    check(!vseen, "R6", "no valid on partial", vseen, 0);
    check(!sym_valid, "R8", "valid with timeout", sym_valid, 0);
    @(negedge clk);
    check(!tmo_err, "R6", "timeout width", tmo_err, 0);
    repeat (2) @(negedge clk);
    send({2'd1, 2'd0, 2'd3, 2'd2}, "R6", m);    // recovery: order 2,3,0,1

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule